// File: doc/BRIEF.md
# Fixed-Latency Register Bus Slave

This block sits on a simple processor-to-fabric register bus with a 10-bit address, a 16-bit write path, a 16-bit read path and one write-enable strobe. It holds a bank of control words that the processor writes and user logic consumes. It also holds a bank of status words that user logic supplies and the processor reads. Read data leaves through a register pipeline of fixed depth. The bus master can therefore issue one address per cycle and collect the matching word a known number of cycles later, with no handshake.

Two features keep the values consistent across a whole control step. Control words land first in working registers. User logic sees them only through a shadow copy, and that copy is refreshed at once when a write burst ends. A single-cycle completion pulse marks the same cycle. On the read side, status words are frozen into a snapshot while the processor's read-phase flag is high, so every word read in one phase comes from the same instant.

Top module: `regbus_slave`

## Requirements
- R1: After a synchronous active-low reset, `bus_rdata`, `out_data` and `wr_done` are all zero, and every control and status word reads back as zero until written or sampled.
- R2: In every cycle where `bus_we` is high and `bus_addr` equals i with i below `N_OUT`, control word i takes the value of `bus_wdata` at that clock edge.
- R3: A word addressed in cycle c is on `bus_rdata` in cycle c+4 (not in c+3). Addresses presented in consecutive cycles give their words in consecutive cycles.
- R4: `out_data` (control word i in bits [16*i+15:16*i]) holds its value during a write burst. It takes the complete set of working values in the same cycle that `wr_done` is high.
- R5: `wr_done` is high for exactly one cycle. That cycle is the second cycle after the last cycle of a run of consecutive `bus_we`-high cycles.
- R6: Status word j, taken from `in_data[16*j+15:16*j]`, is read at address `IN_BASE`+j. While `rd_phase` is low the snapshot follows `in_data` with one cycle of delay. While `rd_phase` is high the snapshot holds.
- R7: A read of an address outside 0..`N_OUT`-1 and `IN_BASE`..`IN_BASE`+`N_IN`-1 returns zero.
- R8: A write to an address outside 0..`N_OUT`-1 changes no control word, no shadow word and no status word. This includes the status range.
- R9: In a cycle where `bus_we` is high, the address is also read. The word returned four cycles later is the value just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 10 | Register address for both read and write |
| bus_we | input | 1 | Write strobe, one word per high cycle |
| bus_wdata | input | 16 | Word to be written |
| bus_rdata | output | 16 | Read word, four cycles after its address |
| rd_phase | input | 1 | High while the processor reads status words; freezes the snapshot |
| in_data | input | N_IN*16 | Status words from user logic, word j in bits [16*j+15:16*j] |
| out_data | output | N_OUT*16 | Shadow copy of the control words for user logic |
| wr_done | output | 1 | One-cycle pulse when a write burst has ended and the shadows are refreshed |

## Verification
The bench checks the read word on the exact fourth cycle and also on the cycle before. An off-by-one pipeline therefore shows up as a wrong value rather than a late one. It streams eight addresses back to back, so a pipeline with a bubble or with reordering returns words in the wrong cycles. During a four-word burst it samples the shadow outputs and the pulse every cycle. A design that exposed words early, pulsed per write or pulsed twice would fail there. It writes to unmapped and status addresses and reads them back, and it reads the status bank while new inputs arrive during a read phase. A leaky decoder or an unfrozen snapshot shows up at the ports as the wrong word.

// File: rtl/rbs_pkg.sv
// Shared bus widths and word types for the register bus slave.
// Assumes the bus geometry is fixed: 10-bit address, 16-bit data.
package rbs_pkg;
    localparam int BUS_AW = 10;
    localparam int BUS_DW = 16;
    typedef logic [BUS_AW-1:0] addr_t;
    typedef logic [BUS_DW-1:0] data_t;
endpackage

// File: rtl/rbs_out_bank.sv
// Control word bank: working registers written by the bus, shadow copies
// refreshed when a write burst ends, and the one-cycle completion pulse.
// Assumes a burst is any run of consecutive cycles with bus_we high.
module rbs_out_bank
    import rbs_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  addr_t                 bus_addr,
    input  logic                  bus_we,
    input  data_t                 bus_wdata,
    output logic [N_OUT*BUS_DW-1:0] work_o,
    output logic [N_OUT*BUS_DW-1:0] shadow_o,
    output logic                  wr_done_o
);
    data_t work_q   [N_OUT];
    data_t shadow_q [N_OUT];
    logic  we_d;
    logic  burst_end;

    assign burst_end = we_d & ~bus_we;

    // Store bus writes that hit a mapped control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_OUT; i++) work_q[i] <= '0;
        end else if (bus_we) begin
            for (int i = 0; i < N_OUT; i++)
                if (bus_addr == addr_t'(i)) work_q[i] <= bus_wdata;
        end
    end

    // Track the previous strobe and raise the completion pulse at burst end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_d      <= 1'b0;
            wr_done_o <= 1'b0;
        end else begin
            we_d      <= bus_we;
            wr_done_o <= burst_end;
        end
    end

    // Copy the whole working set into the shadows when the burst ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_OUT; i++) shadow_q[i] <= '0;
        end else if (burst_end) begin
            for (int i = 0; i < N_OUT; i++) shadow_q[i] <= work_q[i];
        end
    end

    // Flatten the word arrays onto the output vectors.
    for (genvar g = 0; g < N_OUT; g++) begin : g_flat
        assign work_o[g*BUS_DW +: BUS_DW]   = work_q[g];
        assign shadow_o[g*BUS_DW +: BUS_DW] = shadow_q[g];
    end

    // R5: the completion pulse never lasts two cycles.
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done_o |=> !wr_done_o);

    // R4: user-visible shadows move only in the pulse cycle.
    p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_done_o |-> $stable(shadow_o));

    // R8: writes outside the control range leave the working bank alone.
    p_unmapped_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (int'(bus_addr) >= N_OUT)) |=> $stable(work_o));
endmodule

// File: rtl/rbs_in_snap.sv
// Status snapshot: follows the user inputs while no read phase is active
// and freezes while the read-phase flag is high.
// Assumes rd_phase is synchronous to clk.
module rbs_in_snap
    import rbs_pkg::*;
#(
    parameter int N_IN = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_phase,
    input  logic [N_IN*BUS_DW-1:0] in_data,
    output logic [N_IN*BUS_DW-1:0] snap_o
);
    // Sample inputs only outside the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n)        snap_o <= '0;
        else if (!rd_phase) snap_o <= in_data;
    end

    // R6: a read phase holds the snapshot.
    p_snap_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_phase |=> $stable(snap_o));
endmodule

// File: rtl/rbs_rd_pipe.sv
// Fixed-latency read path: address register, decode and select, then a
// chain of data registers so a word appears READ_LAT cycles after its address.
// Assumes READ_LAT >= 2 and the two address ranges do not overlap.
module rbs_rd_pipe
    import rbs_pkg::*;
#(
    parameter int N_OUT    = 8,
    parameter int N_IN     = 8,
    parameter int IN_BASE  = 512,
    parameter int READ_LAT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  addr_t                   bus_addr,
    input  logic [N_OUT*BUS_DW-1:0] out_words,
    input  logic [N_IN*BUS_DW-1:0]  in_words,
    output data_t                   bus_rdata
);
    localparam int NDLY = READ_LAT - 1;

    addr_t addr_q;
    data_t sel;
    data_t dly_q [NDLY];

    // Register the address presented on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= bus_addr;
    end

    // Pick the addressed word; anything unmapped reads as zero.
    always_comb begin
        sel = '0;
        for (int i = 0; i < N_OUT; i++)
            if (int'(addr_q) == i) sel = out_words[i*BUS_DW +: BUS_DW];
        for (int j = 0; j < N_IN; j++)
            if (int'(addr_q) == IN_BASE + j) sel = in_words[j*BUS_DW +: BUS_DW];
    end

    // Shift the selected word down the delay chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NDLY; k++) dly_q[k] <= '0;
        end else begin
            dly_q[0] <= sel;
            for (int k = 1; k < NDLY; k++) dly_q[k] <= dly_q[k-1];
        end
    end

    assign bus_rdata = dly_q[NDLY-1];

    if (READ_LAT == 4) begin : g_lat4_chk
        logic unmapped;
        assign unmapped = (int'(bus_addr) >= N_OUT) &&
                          !((int'(bus_addr) >= IN_BASE) &&
                            (int'(bus_addr) < IN_BASE + N_IN));
        // R7: an unmapped address yields zero four cycles later.
        p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            unmapped |-> ##4 (bus_rdata == '0));
    end
endmodule

// File: rtl/regbus_slave.sv
// Register bus slave top: control word bank with shadows and burst pulse,
// status snapshot gated by the read-phase flag, fixed-latency read pipeline.
// Assumes control words at 0..N_OUT-1 and status words at IN_BASE..IN_BASE+N_IN-1.
module regbus_slave
    import rbs_pkg::*;
#(
    parameter int N_OUT    = 8,
    parameter int N_IN     = 8,
    parameter int IN_BASE  = 512,
    parameter int READ_LAT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [9:0]              bus_addr,
    input  logic                    bus_we,
    input  logic [15:0]             bus_wdata,
    output logic [15:0]             bus_rdata,
    input  logic                    rd_phase,
    input  logic [N_IN*16-1:0]      in_data,
    output logic [N_OUT*16-1:0]     out_data,
    output logic                    wr_done
);
    logic [N_OUT*BUS_DW-1:0] work_w;
    logic [N_IN*BUS_DW-1:0]  snap_w;

    rbs_out_bank #(.N_OUT(N_OUT)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .work_o   (work_w),
        .shadow_o (out_data),
        .wr_done_o(wr_done)
    );

    rbs_in_snap #(.N_IN(N_IN)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_phase(rd_phase),
        .in_data (in_data),
        .snap_o  (snap_w)
    );

    rbs_rd_pipe #(
        .N_OUT   (N_OUT),
        .N_IN    (N_IN),
        .IN_BASE (IN_BASE),
        .READ_LAT(READ_LAT)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .out_words(work_w),
        .in_words (snap_w),
        .bus_rdata(bus_rdata)
    );
endmodule

// File: tb/tb_regbus_slave.sv
// Directed bench for regbus_slave: one task per scenario, each self-checking.
module tb_regbus_slave;
    localparam int NO   = 8;
    localparam int NI   = 8;
    localparam int BASE = 512;
    localparam logic [9:0] IDLE_A = 10'h3FF;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [9:0]       bus_addr;
    logic             bus_we;
    logic [15:0]      bus_wdata;
    logic [15:0]      bus_rdata;
    logic             rd_phase;
    logic [NI*16-1:0] in_data;
    logic [NO*16-1:0] out_data;
    logic             wr_done;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [15:0] exp_reg [NO];
    logic [15:0] exp_sh  [NO];

    always #4 clk = ~clk;

    regbus_slave #(.N_OUT(NO), .N_IN(NI), .IN_BASE(BASE), .READ_LAT(4)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_phase(rd_phase),
        .in_data(in_data), .out_data(out_data), .wr_done(wr_done)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_addr = IDLE_A; bus_we = 1'b0; bus_wdata = '0;
    endtask

    // Contiguous write burst, then wait for the pulse to pass.
    task automatic wr_seq(int first, int n, logic [15:0] v0, logic [15:0] step);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bus_addr = 10'(first + k); bus_we = 1'b1; bus_wdata = v0 + 16'(k) * step;
            exp_reg[first + k] = bus_wdata;
        end
        @(negedge clk); idle();
        repeat (3) @(negedge clk);
        for (int i = 0; i < NO; i++) exp_sh[i] = exp_reg[i];
    endtask

    // Present one address, sample the word four cycles later.
    task automatic rd_chk(logic [9:0] a, logic [15:0] exp, string req);
        @(negedge clk); bus_addr = a; bus_we = 1'b0;
        @(negedge clk); bus_addr = IDLE_A;
        repeat (3) @(negedge clk);
        chk(req, 32'(bus_rdata), 32'(exp));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; rd_phase = 1'b0; in_data = '0; idle();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata", 32'(bus_rdata), 0);
        chk("R1 wr_done", 32'(wr_done), 0);
        for (int i = 0; i < NO; i++) chk("R1 out_data", 32'(out_data[i*16 +: 16]), 0);
        rd_chk(10'd5, 16'h0, "R1 readback");
        for (int i = 0; i < NO; i++) begin exp_reg[i] = '0; exp_sh[i] = '0; end
    endtask

    task automatic t_latency();
        wr_seq(3, 1, 16'hA5C3, 16'h0);
        repeat (4) @(negedge clk);
        @(negedge clk); bus_addr = 10'd3;
        @(negedge clk); bus_addr = IDLE_A;
        repeat (2) @(negedge clk);
        chk("R3 not early", 32'(bus_rdata), 0);
        @(negedge clk);
        chk("R3 R2 R10 on cycle 4", 32'(bus_rdata), 32'h0000A5C3);
    endtask

    task automatic t_back_to_back();
        wr_seq(0, NO, 16'h1000, 16'h0111);
        for (int k = 0; k < NO + 5; k++) begin
            @(negedge clk);
            if (k >= 4 && k - 4 < NO) chk("R3 stream", 32'(bus_rdata), 32'(exp_reg[k-4]));
            bus_addr = (k < NO) ? 10'(k) : IDLE_A;
        end
    endtask

    task automatic t_burst_shadow();
        logic [15:0] old_sh [NO];
        for (int i = 0; i < NO; i++) old_sh[i] = exp_sh[i];
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (k >= 1) begin
                chk("R5 pulse timing", 32'(wr_done), (k == 5) ? 1 : 0);
                for (int i = 0; i < 4; i++)
                    chk("R4 shadow", 32'(out_data[i*16 +: 16]),
                        32'((k >= 5) ? exp_reg[i] : old_sh[i]));
            end
            if (k < 4) begin
                bus_addr = 10'(k); bus_we = 1'b1; bus_wdata = 16'hBE00 + 16'(k);
                exp_reg[k] = bus_wdata;
            end else idle();
        end
        for (int i = 0; i < NO; i++) exp_sh[i] = exp_reg[i];
    endtask

    task automatic t_inputs();
        for (int j = 0; j < NI; j++) in_data[j*16 +: 16] = 16'hC000 + 16'(j);
        repeat (2) @(negedge clk);
        rd_chk(10'(BASE + 2), 16'hC002, "R6 live read");
        @(negedge clk);
        rd_phase = 1'b1;
        for (int j = 0; j < NI; j++) in_data[j*16 +: 16] = 16'h7700 + 16'(j);
        rd_chk(10'(BASE + 2), 16'hC002, "R6 frozen");
        rd_chk(10'(BASE + NI - 1), 16'hC007, "R6 frozen last");
        @(negedge clk); rd_phase = 1'b0;
        repeat (2) @(negedge clk);
        rd_chk(10'(BASE + NI - 1), 16'h7707, "R6 after phase");
        rd_chk(10'(BASE), 16'h7700, "R6 first word");
    endtask

    task automatic t_unmapped();
        logic [9:0] bad [4];
        bad[0] = IDLE_A; bad[1] = 10'(NO); bad[2] = 10'(BASE); bad[3] = 10'(BASE + NI);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); bus_addr = bad[k]; bus_we = 1'b1; bus_wdata = 16'hDEAD;
        end
        @(negedge clk); idle();
        repeat (3) @(negedge clk);
        for (int i = 0; i < NO; i++) chk("R8 shadow kept", 32'(out_data[i*16 +: 16]), 32'(exp_sh[i]));
        rd_chk(10'd0, exp_reg[0], "R8 word0 kept");
        rd_chk(10'(NO - 1), exp_reg[NO-1], "R8 last word kept");
        rd_chk(10'(BASE), 16'h7700, "R8 status kept");
        rd_chk(IDLE_A, 16'h0, "R7 top address");
        rd_chk(10'(NO), 16'h0, "R7 past control");
        rd_chk(10'(BASE + NI), 16'h0, "R7 past status");
    endtask

    task automatic t_read_during_write();
        @(negedge clk); bus_addr = 10'd5; bus_we = 1'b1; bus_wdata = 16'h5A5A;
        exp_reg[5] = 16'h5A5A;
        @(negedge clk); idle();
        repeat (3) @(negedge clk);
        chk("R9 new value", 32'(bus_rdata), 32'h00005A5A);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_back_to_back();
        t_burst_shadow();
        t_inputs();
        t_unmapped();
        t_read_during_write();
        repeat (4) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule